// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block supplies the control-memory address for every clock cycle of a microprogrammed control unit. It keeps a control address register and, on each rising clock edge, reloads it from one of four sources: the register plus one, the jump address carried by the current microinstruction, the most recent saved return address, or an address mapped from an instruction opcode outside the block.

The current microinstruction is 20 bits wide. It holds three 3-bit micro-operation fields, a 2-bit condition select, a 2-bit branch type and a 7-bit address. Only the condition select, the branch type and the address reach this block. The condition select picks one status bit through a multiplexer, and that test bit drives a small truth table together with the branch type. The truth table chooses the source and says whether a return address is saved or consumed.

The return addresses are kept in a last-in first-out store whose depth is a parameter. A depth of 1 gives a single return register; a power-of-two depth up to 8 gives a stack. The control memory, the micro-operation fields and the datapath belong to neighbouring blocks.

Top module: `useq_next_addr`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets car_o to 0 at that edge. A reset also empties the return store.
- R2: cond_sel_i value k (0 to 3) selects status_i[k] as the test bit T. No other status bit changes the next address.
- R3: With br_type_i = 2'b00 (conditional jump), car_o becomes jump_addr_i when T = 1 and car_o + 1 when T = 0. No return address is saved.
- R4: With br_type_i = 2'b01 (conditional call), a true T loads car_o with jump_addr_i and saves car_o + 1 as a return address. A false T loads car_o + 1.
- R5: With br_type_i = 2'b10 (return), car_o becomes the most recently saved return address whatever T is, and that entry is removed.
- R6: With br_type_i = 2'b11 (dispatch), car_o becomes map_addr_i whatever T is.
- R7: Nested calls up to RET_DEPTH levels return in last-in first-out order.
- R8: A call whose condition is false saves nothing. A later return yields the address saved by the older call.
- R9: The increment wraps modulo 2^ADDR_W, so 127 steps to 0 at the default width.
- R10: The source select uses the encoding 00 for increment, 01 for the jump address, 10 for the return store and 11 for the mapped address. A save happens only together with source 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cond_sel_i | input | 2 | Condition select field of the current microinstruction |
| br_type_i | input | 2 | Branch type field of the current microinstruction |
| jump_addr_i | input | 7 | Address field of the current microinstruction |
| status_i | input | 4 | Status bits that can be tested |
| map_addr_i | input | 7 | Control-memory address mapped from the instruction opcode |
| car_o | output | 7 | Control address register, the control-memory address |

## Verification
The assertions assume that the microprogram never returns with an empty return store and never calls with a true condition while all RET_DEPTH entries are in use. Overflow and underflow are left unchecked, so a stored address there is meaningless. The assertions also assume that the inputs are stable around the clock edge. The random stimulus follows a model of the store depth: it turns a return with an empty store, or a call with a full store, into a conditional jump, and it changes inputs only on the falling edge.

// File: rtl/useq_pkg.sv
package useq_pkg;
   typedef enum logic [1:0] {
      SRC_INC = 2'b00,
      SRC_AD  = 2'b01,
      SRC_RET = 2'b10,
      SRC_MAP = 2'b11
   } src_e;

   typedef enum logic [1:0] {
      BR_JUMP = 2'b00,
      BR_CALL = 2'b01,
      BR_RET  = 2'b10,
      BR_MAP  = 2'b11
   } br_e;
endpackage

// File: rtl/useq_cond_sel.sv
module useq_cond_sel #(
   parameter int NUM_COND = 4,
   localparam int SEL_W = $clog2(NUM_COND)
) (
   input  logic [SEL_W-1:0]    sel_i,
   input  logic [NUM_COND-1:0] status_i,
   output logic                test_o
);
   if (NUM_COND < 2 || (NUM_COND & (NUM_COND - 1)) != 0) begin : g_bad_cond
      $error("useq_cond_sel: NUM_COND must be a power of two of at least 2");
   end

   assign test_o = status_i[sel_i];
endmodule

// File: rtl/useq_input_logic.sv
module useq_input_logic
   import useq_pkg::*;
(
   input  logic [1:0] br_i,
   input  logic       test_i,
   output src_e       src_o,
   output logic       push_o,
   output logic       pop_o
);
   always_comb begin
      src_o  = SRC_INC;
      push_o = 1'b0;
      pop_o  = 1'b0;
      case (br_i)
         BR_JUMP: if (test_i) src_o = SRC_AD;
         BR_CALL: if (test_i) begin
            src_o  = SRC_AD;
            push_o = 1'b1;
         end
         BR_RET: begin
            src_o = SRC_RET;
            pop_o = 1'b1;
         end
         default: src_o = SRC_MAP;
      endcase
   end

   always_comb begin
      AST_SAVE_WITH_JUMP: assert (!push_o || (src_o == SRC_AD && !pop_o)) else $error("save without jump source"); // R10
   end
endmodule

// File: rtl/useq_ret_stack.sv
module useq_ret_stack #(
   parameter int ADDR_W = 7,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [ADDR_W-1:0] push_data_i,
   output logic [ADDR_W-1:0] top_o
);
   if (DEPTH < 1 || DEPTH > 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("useq_ret_stack: DEPTH must be 1, 2, 4 or 8");
   end

   if (DEPTH == 1) begin : g_single
      logic [ADDR_W-1:0] ret_q;
      always_ff @(posedge clk) begin
         if (rst)         ret_q <= '0;
         else if (push_i) ret_q <= push_data_i;
      end
      assign top_o = ret_q;
   end else begin : g_stack
      localparam int PTR_W = $clog2(DEPTH);
      logic [ADDR_W-1:0] mem_q [DEPTH];
      logic [PTR_W-1:0]  sp_q;
      logic [PTR_W-1:0]  top_idx;

      assign top_idx = sp_q - 1'b1;
      assign top_o   = mem_q[top_idx];

      always_ff @(posedge clk) begin
         if (rst) begin
            sp_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         end else if (push_i) begin
            mem_q[sp_q] <= push_data_i;
            sp_q        <= sp_q + 1'b1;
         end else if (pop_i) begin
            sp_q <= top_idx;
         end
      end
   end

   AST_PUSH_ON_TOP: assert property (@(posedge clk) disable iff (rst)
      push_i |=> top_o == $past(push_data_i)) else $error("pushed address not on top"); // R7
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
   import useq_pkg::*;
#(
   parameter int ADDR_W    = 7,
   parameter int NUM_COND  = 4,
   parameter int RET_DEPTH = 4,
   localparam int CD_W = $clog2(NUM_COND)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [CD_W-1:0]     cond_sel_i,
   input  logic [1:0]          br_type_i,
   input  logic [ADDR_W-1:0]   jump_addr_i,
   input  logic [NUM_COND-1:0] status_i,
   input  logic [ADDR_W-1:0]   map_addr_i,
   output logic [ADDR_W-1:0]   car_o
);
   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
      $error("useq_next_addr: ADDR_W out of range 2..16");
   end

   logic [ADDR_W-1:0] car_q;
   logic [ADDR_W-1:0] car_inc;
   logic [ADDR_W-1:0] car_next;
   logic [ADDR_W-1:0] ret_addr;
   logic              test;
   logic              push;
   logic              pop;
   src_e              src;

   assign car_inc = car_q + 1'b1;

   useq_cond_sel #(.NUM_COND(NUM_COND)) i_cond_sel (
      .sel_i    (cond_sel_i),
      .status_i (status_i),
      .test_o   (test)
   );

   useq_input_logic i_input_logic (
      .br_i   (br_type_i),
      .test_i (test),
      .src_o  (src),
      .push_o (push),
      .pop_o  (pop)
   );

   useq_ret_stack #(.ADDR_W(ADDR_W), .DEPTH(RET_DEPTH)) i_ret_stack (
      .clk         (clk),
      .rst         (rst),
      .push_i      (push),
      .pop_i       (pop),
      .push_data_i (car_inc),
      .top_o       (ret_addr)
   );

   always_comb begin
      case (src)
         SRC_INC: car_next = car_inc;
         SRC_AD:  car_next = jump_addr_i;
         SRC_RET: car_next = ret_addr;
         default: car_next = map_addr_i;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) car_q <= '0;
      else     car_q <= car_next;
   end

   assign car_o = car_q;

   AST_RESET_ZERO: assert property (@(posedge clk)
      rst |=> car_o == '0) else $error("reset did not clear address"); // R1
   AST_MAP_DISPATCH: assert property (@(posedge clk) disable iff (rst)
      br_type_i == 2'b11 |=> car_o == $past(map_addr_i)) else $error("dispatch missed"); // R6
   AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (br_type_i[1] == 1'b0 && status_i[cond_sel_i]) |=> car_o == $past(jump_addr_i)) else $error("taken branch missed"); // R3
   AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
      (br_type_i[1] == 1'b0 && !status_i[cond_sel_i]) |=> car_o == ADDR_W'($past(car_o) + 1'b1)) else $error("fall-through missed"); // R4
endmodule

// File: tb/test_useq_next_addr.sv
module test_useq_next_addr;
   localparam int DEPTH = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] cd  = '0;
   logic [1:0] br  = '0;
   logic [6:0] ad  = '0;
   logic [3:0] st  = '0;
   logic [6:0] mp  = '0;
   logic [6:0] car;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [6:0] m_car;
   logic [6:0] m_stk [DEPTH];
   int         m_sp;

   always #10 clk = ~clk; // 20 time units: 50 MHz with 1 ns units

   useq_next_addr i_useq_next_addr (
      .clk(clk), .rst(rst), .cond_sel_i(cd), .br_type_i(br),
      .jump_addr_i(ad), .status_i(st), .map_addr_i(mp), .car_o(car)
   );

   task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s car_o=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Expected next address from the requirements; updates the model store.
   function automatic logic [6:0] model_next(input logic [1:0] c, input logic [1:0] b,
                                             input logic [6:0] a, input logic [3:0] s,
                                             input logic [6:0] m);
      logic t = s[c];
      logic [6:0] nxt;
      case (b)
         2'b00: nxt = t ? a : m_car + 7'd1;
         2'b01: begin
            if (t) begin
               m_stk[m_sp] = m_car + 7'd1;
               m_sp++;
               nxt = a;
            end else nxt = m_car + 7'd1;
         end
         2'b10: begin
            m_sp--;
            nxt = m_stk[m_sp];
         end
         default: nxt = m;
      endcase
      return nxt;
   endfunction

   task automatic step(input string req, input logic [1:0] c, input logic [1:0] b,
                       input logic [6:0] a, input logic [3:0] s, input logic [6:0] m);
      @(negedge clk);
      cd = c; br = b; ad = a; st = s; mp = m;
      m_car = model_next(c, b, a, s, m);
      @(posedge clk);
      #3;
      check(req, car, m_car);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #3;
      m_car = '0;
      m_sp  = 0;
      check("R1", car, 7'd0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      m_car = '0;
      m_sp  = 0;
      void'($urandom(32'd20240611));
      do_reset();

      // R2: each condition select picks only its own status bit
      for (int k = 0; k < 4; k++) begin
         step("R2", 2'(k), 2'b00, 7'(20 + k), 4'(1 << k), 7'd0);
         step("R2", 2'(k), 2'b00, 7'd99, ~4'(1 << k), 7'd0);
      end
      // R3: jump taken and not taken
      step("R3", 2'd1, 2'b00, 7'd50, 4'b0010, 7'd0);
      step("R3", 2'd1, 2'b00, 7'd10, 4'b1101, 7'd0);
      // R6: dispatch regardless of T
      step("R6", 2'd0, 2'b11, 7'd3, 4'b0000, 7'd127);
      // R9: wrap from 127 to 0
      step("R9", 2'd0, 2'b00, 7'd5, 4'b0000, 7'd0);
      step("R6", 2'd2, 2'b11, 7'd3, 4'b1111, 7'd40);
      // R8/R4: false call saves nothing, true call saves car+1
      step("R4", 2'd3, 2'b01, 7'd70, 4'b0000, 7'd0);
      step("R4", 2'd3, 2'b01, 7'd70, 4'b1000, 7'd0);
      step("R8", 2'd3, 2'b01, 7'd90, 4'b0111, 7'd0);
      step("R5", 2'd0, 2'b10, 7'd0, 4'b0001, 7'd0);
      // R7: nested calls to full depth, LIFO returns, T ignored on return
      for (int k = 0; k < DEPTH; k++)
         step("R7", 2'd0, 2'b01, 7'(30 * k + 7), 4'b0001, 7'd0);
      for (int k = 0; k < DEPTH; k++)
         step("R7", 2'(k), 2'b10, 7'd0, 4'(k * 5), 7'd0);

      // R1: reset in the middle of a run
      step("R6", 2'd0, 2'b11, 7'd0, 4'b0, 7'd77);
      do_reset();

      // Constrained random traffic, kept within the store depth
      for (int n = 0; n < 3000; n++) begin
         logic [1:0] c = 2'($urandom_range(0, 3));
         logic [1:0] b = 2'($urandom_range(0, 3));
         logic [3:0] s = 4'($urandom_range(0, 15));
         if (b == 2'b10 && m_sp == 0) b = 2'b00;
         if (b == 2'b01 && s[c] && m_sp == DEPTH) b = 2'b00;
         step("R10", c, b, 7'($urandom_range(0, 127)), s, 7'($urandom_range(0, 127)));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule